// File: doc/BRIEF.md
# Three-Wire Codec Register Writer

This block programs the configuration registers of an audio codec over a three-wire serial link. The three lines are a serial clock, a serial data line and a mode line. The level of the mode line tells the codec how to read the data line. While the mode line is low, the shifted bits are a register address. While it is high, the shifted bits are the value to write.

A host presents one request, qualified by a valid strobe. The request holds an address byte, a byte count from 1 to 4, and up to four data bytes packed lowest byte first. The block sends the address byte with the mode line low. It then waits through a guard gap, raises the mode line, and sends the data bytes in turn. The serial clock comes from a divider of the system clock, so its rate never exceeds a configured maximum. A typical use is a status-register write that sets the codec's system-clock ratio (256, 384 or 512 times the sample rate) through a two-bit field. The block reports `busy` for the whole transfer and pulses `done` when the transfer ends.

Top module: `cfg3w_writer`

## Requirements
- R1: After reset, and at any time the block is not busy, the serial clock is high, the mode line is low and `busy` is low. Immediately after reset, the serial data line and `done` are also low.
- R2: The address byte goes out first, while the mode line is low. It is sent as 8 bits, least significant bit first, and each bit is valid at a rising edge of the serial clock.
- R3: The data bytes follow while the mode line is high, each least significant bit first. The first data byte is `req_data[7:0]`, the second is `req_data[15:8]`, and so on.
- R4: A request with `req_count` from 1 to 4 sends exactly that many data bytes, so the transfer holds 8*(count+1) rising clock edges. A request with count 0 or 5 to 7 is ignored: `busy` stays low and the serial clock does not toggle.
- R5: The serial data line changes only while the serial clock is low. It is set up at the falling edge and is stable at the rising edge.
- R6: Each high and low phase of the serial clock within a byte lasts HALF = ceil(SYS_CLK_HZ / (2*SCL_MAX_HZ)) system cycles. With the default parameters this is 25 cycles, which gives a 1 MHz clock.
- R7: Between the last rising edge of the address byte and the first falling edge of the data phase there are at least GAP_PERIODS (default 2) serial clock periods with the clock held high. The mode line changes inside that gap, never while the clock is low.
- R8: Between two data bytes, the serial clock stays high for at least one full serial period.
- R9: `done` is high for exactly one system cycle, HALF cycles after the last rising edge. In that same cycle `busy` goes low and the mode line returns low.
- R10: A request that arrives while `busy` is high is ignored. The transfer in progress finishes with its original content, and no further transfer follows.
- R11: A valid request held during the cycle in which `done` is high is accepted: `busy` is high in the next cycle, and the new transfer is sent in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request strobe |
| req_addr | input | 8 | Register address byte |
| req_count | input | 3 | Number of data bytes (1 to 4) |
| req_data | input | 32 | Data bytes, first byte in bits 7:0 |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| ser_clk | output | 1 | Serial clock to the codec |
| ser_data | output | 1 | Serial data to the codec |
| ser_mode | output | 1 | Mode line: low for address, high for data |

## Verification
The end of one transfer and the acceptance of the next can meet in the same cycle. `done` rises in the same edge that returns the sequencer to idle, so a request held during that pulse is taken at the very next edge. The bench provokes this by watching for `done` and driving a new request in that same cycle. It then judges that `busy` is high one cycle later, and that both the finished frame and the new frame arrive bit-exact, with the mode levels and clock timing unchanged.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_WAIT,
      SEQ_SHIFT,
      SEQ_FINISH
   } seq_state_t;
endpackage

// File: rtl/cfg3w_tick_gen.sv
module cfg3w_tick_gen #(
   parameter int HALF = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

   generate
      if (HALF < 1) begin : g_bad_half
         $error("cfg3w_tick_gen: HALF must be at least 1");
      end
      if (HALF == 1) begin : g_every
         logic unused_inputs;
         assign unused_inputs = ^{clk, rst_n, restart};
         assign tick = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n || restart) cnt <= '0;
            else if (cnt == CW'(HALF - 1)) cnt <= '0;
            else cnt <= cnt + 1'b1;
         end
         assign tick = (cnt == CW'(HALF - 1));
      end
   endgenerate
endmodule

// File: rtl/cfg3w_shifter.sv
module cfg3w_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   output logic         bit_out
);
   logic [W-1:0] sr;

   generate
      if (W < 2) begin : g_bad_w
         $error("cfg3w_shifter: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) sr <= '0;
      else if (load) sr <= load_val;
      else if (shift) sr <= {1'b0, sr[W-1:1]};
   end

   assign bit_out = sr[0];
endmodule

// File: rtl/cfg3w_writer.sv
module cfg3w_writer #(
   parameter int SYS_CLK_HZ  = 50_000_000,
   parameter int SCL_MAX_HZ  = 1_000_000,
   parameter int BYTE_W      = 8,
   parameter int MAX_BYTES   = 4,
   parameter int GAP_PERIODS = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   input  logic [BYTE_W-1:0]             req_addr,
   input  logic [$clog2(MAX_BYTES+1)-1:0] req_count,
   input  logic [MAX_BYTES*BYTE_W-1:0]   req_data,
   output logic                          busy,
   output logic                          done,
   output logic                          ser_clk,
   output logic                          ser_data,
   output logic                          ser_mode
);
   import cfg3w_pkg::*;

   localparam int HALF      = (SYS_CLK_HZ + 2*SCL_MAX_HZ - 1) / (2*SCL_MAX_HZ);
   localparam int CNT_W     = $clog2(MAX_BYTES + 1);
   localparam int BIT_W     = $clog2(BYTE_W);
   localparam int GAP_TICKS = 2 * GAP_PERIODS;
   localparam int WAIT_W    = $clog2(GAP_TICKS + 1);

   generate
      if (SCL_MAX_HZ < 1 || SYS_CLK_HZ < 2*SCL_MAX_HZ) begin : g_bad_rate
         $error("cfg3w_writer: system clock must be at least twice the serial clock limit");
      end
      if (MAX_BYTES < 1) begin : g_bad_bytes
         $error("cfg3w_writer: MAX_BYTES must be at least 1");
      end
      if (GAP_PERIODS < 1) begin : g_bad_gap
         $error("cfg3w_writer: GAP_PERIODS must be at least 1");
      end
   endgenerate

   seq_state_t                  state;
   logic [WAIT_W-1:0]           wait_cnt;
   logic                        flip_pend;
   logic                        rise_next;
   logic [BIT_W-1:0]            bit_idx;
   logic [CNT_W-1:0]            byte_idx;
   logic [CNT_W-1:0]            count_r;
   logic [MAX_BYTES*BYTE_W-1:0] data_r;

   logic              tick;
   logic              accept;
   logic              byte_end;
   logic              sh_load;
   logic              sh_shift;
   logic              sh_bit;
   logic [BYTE_W-1:0] sh_val;
   logic [BYTE_W-1:0] next_byte;

   assign accept = (state == SEQ_IDLE) && req_valid &&
                   (req_count != '0) && (req_count <= CNT_W'(MAX_BYTES));

   assign byte_end = (state == SEQ_SHIFT) && tick && rise_next &&
                     (bit_idx == BIT_W'(BYTE_W - 1));

   always_comb begin
      next_byte = '0;
      for (int i = 0; i < MAX_BYTES; i++) begin
         if (int'(byte_idx) == i) next_byte = data_r[i*BYTE_W +: BYTE_W];
      end
   end

   assign sh_load  = accept || (byte_end && (byte_idx != count_r));
   assign sh_val   = accept ? req_addr : next_byte;
   assign sh_shift = (state == SEQ_SHIFT) && tick && rise_next;

   cfg3w_tick_gen #(.HALF(HALF)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (accept),
      .tick    (tick)
   );

   cfg3w_shifter #(.W(BYTE_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sh_load),
      .load_val (sh_val),
      .shift    (sh_shift),
      .bit_out  (sh_bit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= SEQ_IDLE;
         wait_cnt  <= '0;
         flip_pend <= 1'b0;
         rise_next <= 1'b0;
         bit_idx   <= '0;
         byte_idx  <= '0;
         count_r   <= '0;
         data_r    <= '0;
         busy      <= 1'b0;
         done      <= 1'b0;
         ser_clk   <= 1'b1;
         ser_data  <= 1'b0;
         ser_mode  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            SEQ_IDLE: begin
               if (accept) begin
                  count_r   <= req_count;
                  data_r    <= req_data;
                  byte_idx  <= '0;
                  busy      <= 1'b1;
                  ser_mode  <= 1'b0;
                  wait_cnt  <= WAIT_W'(1);
                  flip_pend <= 1'b0;
                  state     <= SEQ_WAIT;
               end
            end
            SEQ_WAIT: begin
               if (tick) begin
                  if (flip_pend && wait_cnt == WAIT_W'(GAP_PERIODS)) ser_mode <= 1'b1;
                  if (wait_cnt == '0) begin
                     ser_clk   <= 1'b0;
                     ser_data  <= sh_bit;
                     rise_next <= 1'b1;
                     bit_idx   <= '0;
                     state     <= SEQ_SHIFT;
                  end else begin
                     wait_cnt <= wait_cnt - 1'b1;
                  end
               end
            end
            SEQ_SHIFT: begin
               if (tick) begin
                  if (rise_next) begin
                     ser_clk   <= 1'b1;
                     rise_next <= 1'b0;
                     if (byte_end) begin
                        if (byte_idx == count_r) begin
                           state <= SEQ_FINISH;
                        end else begin
                           byte_idx  <= byte_idx + 1'b1;
                           flip_pend <= (byte_idx == '0);
                           wait_cnt  <= (byte_idx == '0) ? WAIT_W'(GAP_TICKS - 1) : WAIT_W'(1);
                           state     <= SEQ_WAIT;
                        end
                     end else begin
                        bit_idx <= bit_idx + 1'b1;
                     end
                  end else begin
                     ser_clk   <= 1'b0;
                     ser_data  <= sh_bit;
                     rise_next <= 1'b1;
                  end
               end
            end
            SEQ_FINISH: begin
               if (tick) begin
                  done     <= 1'b1;
                  busy     <= 1'b0;
                  ser_mode <= 1'b0;
                  state    <= SEQ_IDLE;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   // Idle line levels (R1)
   assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (ser_clk && !ser_mode));

   // Only legal counts ever reach the sequencer (R4)
   assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (count_r != '0 && count_r <= CNT_W'(MAX_BYTES)));

   // Data moves only with the clock low (R5)
   assert_data_moves_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ser_data) |-> !ser_clk);

   // Mode changes only while the clock rests high (R7)
   assert_mode_in_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ser_mode) |-> ser_clk);

   // Single-cycle done, busy already dropped (R9)
   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !ser_mode && ser_clk));

   // Requests during a transfer leave the latched request untouched (R10)
   assert_ignore_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_valid) |=> ($stable(count_r) && $stable(data_r)));
endmodule

// File: tb/tb_cfg3w_writer.sv
module tb_cfg3w_writer;
   localparam int HALF_CYC = (50_000_000 / 1_000_000) / 2;
   localparam int NB       = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [2:0]  req_count = '0;
   logic [31:0] req_data = '0;
   logic        busy, done, ser_clk, ser_data, ser_mode;

   int n_checks = 0;
   int n_fail   = 0;

   cfg3w_writer dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .req_count (req_count),
      .req_data  (req_data),
      .busy      (busy),
      .done      (done),
      .ser_clk   (ser_clk),
      .ser_data  (ser_data),
      .ser_mode  (ser_mode)
   );

   always #10 clk = ~clk;

   // Line monitor, sampled away from the active edge
   int   cyc = 0;
   int   nb = 0, nf = 0;
   int   rise_t [NB];
   int   fall_t [NB];
   logic bit_v  [NB];
   logic mode_v [NB];
   int   mode_up_t = 0;
   int   bad_data_chg = 0;
   int   done_n = 0, done_t = 0, done_busy_bad = 0;
   logic prev_clk = 1'b1, prev_data = 1'b0, prev_mode = 1'b0;

   always @(negedge clk) begin
      cyc++;
      if (ser_clk && !prev_clk && nb < NB) begin
         rise_t[nb] = cyc; bit_v[nb] = ser_data; mode_v[nb] = ser_mode; nb++;
      end
      if (!ser_clk && prev_clk && nf < NB) begin
         fall_t[nf] = cyc; nf++;
      end
      if (ser_mode && !prev_mode) mode_up_t = cyc;
      if (ser_data != prev_data && ser_clk) bad_data_chg++;
      if (done) begin
         done_n++; done_t = cyc;
         if (busy) done_busy_bad++;
      end
      prev_clk = ser_clk; prev_data = ser_data; prev_mode = ser_mode;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
      end
   endtask

   task automatic mon_clear();
      nb = 0; nf = 0; mode_up_t = 0; bad_data_chg = 0;
      done_n = 0; done_t = 0; done_busy_bad = 0;
   endtask

   task automatic issue(input logic [7:0] a, input logic [2:0] c, input logic [31:0] d);
      @(posedge clk); #2;
      req_valid = 1'b1; req_addr = a; req_count = c; req_data = d;
      @(posedge clk); #2;
      req_valid = 1'b0;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 10000; i++) begin
         @(posedge clk); #2;
         if (done) break;
      end
      @(negedge clk); #1;
   endtask

   task automatic check_frame(input logic [7:0] a, input int c, input logic [31:0] d,
                              input bit with_done);
      int errs;
      chk(nb == 8*(c+1), "R4 rising edge count", nb, 8*(c+1));
      if (nb != 8*(c+1)) return;
      errs = 0;
      for (int i = 0; i < 8; i++) if (bit_v[i] !== a[i] || mode_v[i] !== 1'b0) errs++;
      chk(errs == 0, "R2 address bits with mode low", errs, 0);
      errs = 0;
      for (int i = 0; i < 8*c; i++) if (bit_v[8+i] !== d[i] || mode_v[8+i] !== 1'b1) errs++;
      chk(errs == 0, "R3 data bits with mode high", errs, 0);
      errs = 0;
      for (int i = 0; i < nb; i++) begin
         if (rise_t[i] - fall_t[i] != HALF_CYC) errs++;
         if (i % 8 != 7 && fall_t[i+1] - rise_t[i] != HALF_CYC) errs++;
      end
      chk(errs == 0, "R6 half period length", errs, 0);
      chk(fall_t[8] - rise_t[7] >= 4*HALF_CYC, "R7 mode change gap", fall_t[8] - rise_t[7], 4*HALF_CYC);
      chk(mode_up_t > rise_t[7] && mode_up_t < fall_t[8], "R7 mode rises inside gap",
          mode_up_t, rise_t[7] + 2*HALF_CYC);
      errs = 0;
      for (int k = 1; k < c; k++) if (fall_t[8*k+8] - rise_t[8*k+7] < 2*HALF_CYC) errs++;
      chk(errs == 0, "R8 inter-byte high gap", errs, 0);
      chk(bad_data_chg == 0, "R5 data change while clock high", bad_data_chg, 0);
      if (with_done) begin
         chk(done_n == 1, "R9 done pulse count", done_n, 1);
         chk(done_t - rise_t[nb-1] == HALF_CYC, "R9 done timing", done_t - rise_t[nb-1], HALF_CYC);
         chk(done_busy_bad == 0, "R9 busy low with done", done_busy_bad, 0);
         chk(busy == 1'b0 && ser_mode == 1'b0 && ser_clk == 1'b1, "R9 R1 lines after done",
             {busy, ser_mode, ser_clk}, 3'b001);
      end
   endtask

   task automatic t_reset();
      chk(ser_clk == 1'b1 && ser_mode == 1'b0 && ser_data == 1'b0 && busy == 1'b0 && done == 1'b0,
          "R1 reset levels", {ser_clk, ser_mode, ser_data, busy, done}, 5'b10000);
   endtask

   task automatic t_single(input logic [7:0] a, input int c, input logic [31:0] d);
      mon_clear();
      issue(a, 3'(c), d);
      chk(busy == 1'b1, "R4 busy after valid request", busy, 1);
      wait_done();
      check_frame(a, c, d, 1'b1);
   endtask

   task automatic t_bad_count(input logic [2:0] c);
      mon_clear();
      issue(8'hA5, c, 32'hFFFF_FFFF);
      chk(busy == 1'b0, "R4 bad count ignored busy", busy, 0);
      repeat (200) @(posedge clk);
      @(negedge clk); #1;
      chk(nb == 0 && nf == 0, "R4 bad count no clock", nb + nf, 0);
   endtask

   task automatic t_busy_ignore();
      mon_clear();
      issue(8'h3C, 3'd2, 32'h0000_C35A);
      repeat (300) @(posedge clk);
      issue(8'hFF, 3'd4, 32'h1234_5678);
      wait_done();
      check_frame(8'h3C, 2, 32'h0000_C35A, 1'b1);
      repeat (300) @(posedge clk);
      @(negedge clk); #1;
      chk(busy == 1'b0 && nb == 24, "R10 no second transfer", nb, 24);
   endtask

   task automatic t_back_to_back();
      mon_clear();
      issue(8'h81, 3'd1, 32'h0000_0042);
      for (int i = 0; i < 10000; i++) begin
         @(posedge clk); #2;
         if (done) break;
      end
      req_valid = 1'b1; req_addr = 8'h7E; req_count = 3'd3; req_data = 32'h00A1_B2C3;
      check_frame(8'h81, 1, 32'h0000_0042, 1'b0);
      @(negedge clk); #1;
      mon_clear();
      @(posedge clk); #2;
      req_valid = 1'b0;
      chk(busy == 1'b1, "R11 request in done cycle accepted", busy, 1);
      wait_done();
      check_frame(8'h7E, 3, 32'h00A1_B2C3, 1'b1);
   endtask

   initial begin
      for (int i = 0; i < 200000; i++) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk); #1;
      t_reset();
      t_single(8'h14, 1, 32'h0000_0010);   // clock-ratio status write, R2 R3
      t_single(8'hB6, 4, 32'h89AB_CDEF);   // R3 R8 full count
      t_single(8'h01, 2, 32'h0000_8001);   // R6 timing
      t_bad_count(3'd0);                   // R4
      t_bad_count(3'd5);                   // R4
      t_busy_ignore();                     // R10
      t_back_to_back();                    // R11
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule